// File: doc/BRIEF.md
# Stack push/pop execution sequencer

This block carries out the two stack instructions of a 16-bit, byte-addressed load/store machine. General register 6 serves as the stack pointer. A decoder presents a pulse on `start` together with the operation (`op_pop` low for a push, high for a pop) and a register index. The sequencer then works through a short series of states. In those states it reads the register file through one read port and writes it through one write port. It performs exactly one word transfer on a memory port whose accesses take five cycles. It finishes the instruction with a one-cycle `done` pulse.

A push first moves the stack pointer down by one word (two bytes) and then stores the selected register at the new top. A pop first loads the word at the current top into the selected register and then moves the pointer up by two. A pop also sets a one-hot negative/zero/positive flag set from the loaded word. The block accepts a new instruction only when it is idle, and it ignores `start` while an instruction is in progress.

Top module: `stk_seq`

## Requirements
- R1: A push writes register 6 with its old value minus 2, then performs one memory write of the source register's value to the byte address equal to that new register 6 value.
- R2: A push whose source index is 6 stores the already decremented stack pointer value.
- R3: A pop performs one memory read at the byte address held in register 6, writes the word to the destination register, and then writes register 6 with its current value plus 2. When the destination is register 6, the increment applies to the loaded word.
- R4: After a pop, `cc_nzp` is one-hot with bit 2 = negative (bit 15 of the loaded word set), bit 1 = zero (word equal to 0), bit 0 = positive (any other value).
- R5: A push leaves `cc_nzp` unchanged.
- R6: During a memory access, `mem_en` stays high and `mem_addr`, `mem_we` and `mem_wdata` stay stable until the cycle in which `mem_ready` is high. `mem_ready` arrives in the fifth cycle of the access, and that is the last cycle of the access.
- R7: `done` is high for exactly one cycle per instruction. Counting clock edges from the edge that accepts `start`, `done` is high after the 7th edge for a push and after the 8th edge for a pop.
- R8: While an instruction is in progress, `start` has no effect: no extra access, register write or `done` pulse results from it.
- R9: While reset is applied, `done`, `mem_en` and `rf_we` are low and `cc_nzp` equals 3'b010.
- R10: Stack pointer arithmetic wraps modulo 2^16: a push from 0x0000 gives 0xFFFE, and a pop from 0xFFFE gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin an instruction; sampled only when idle |
| op_pop | input | 1 | 0 = push, 1 = pop |
| reg_sel | input | 3 | Source (push) or destination (pop) register index |
| done | output | 1 | One-cycle pulse at the end of each instruction |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| mem_en | output | 1 | Memory access active |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes in this cycle |
| cc_nzp | output | 3 | Condition flags {N,Z,P} |

## Verification
If the sequencer entered a wrong state, the fault would reach the ports within one instruction. The `done` pulse would come at the wrong edge, or one register or memory word would differ from the value the bench models after that `done`. A corrupted pointer step or address register shows up as a wrong register 6 value, or as a store to a wrong word. A wrong flag load shows up on `cc_nzp` at the `done` of the pop that loaded it, or as a change across a push. Leftover activity from an ignored `start` would show up as a stray `mem_en` or `done` in the quiet window after the instruction.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PU_DEC,
    S_PU_SRC,
    S_PU_MEM,
    S_PO_ADR,
    S_PO_MEM,
    S_PO_WB,
    S_PO_INC
  } stk_state_e;

  // per-state datapath controls
  typedef struct packed {
    logic rd_sp;     // read port addresses the stack pointer
    logic ld_addr;   // load address register
    logic addr_sum;  // address register takes adder output
    logic ld_wdat;   // capture store data from register file
    logic cap_rdat;  // capture load data from memory
    logic mem_en;
    logic mem_we;
    logic rf_we;
    logic wr_sp;     // write targets the stack pointer with adder output
    logic step_dn;   // adder subtracts the step
    logic ld_cc;
    logic done;
  } stk_ctl_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_pop,
  input  logic [RW-1:0] reg_idx,
  input  logic          mem_ready,
  output stk_ctl_t      ctl,
  output logic [RW-1:0] idx_q,
  output logic          pop_q,
  output logic          busy
);

  stk_state_e state_q, state_d;
  logic       accept;

  assign accept = (state_q == S_IDLE) && start;
  assign busy   = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start) state_d = is_pop ? S_PO_ADR : S_PU_DEC;
      S_PU_DEC: state_d = S_PU_SRC;
      S_PU_SRC: state_d = S_PU_MEM;
      S_PU_MEM: if (mem_ready) state_d = S_IDLE;
      S_PO_ADR: state_d = S_PO_MEM;
      S_PO_MEM: if (mem_ready) state_d = S_PO_WB;
      S_PO_WB:  state_d = S_PO_INC;
      S_PO_INC: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pop_q <= 1'b0;
    end else if (accept) begin
      idx_q <= reg_idx;
      pop_q <= is_pop;
    end
  end

  always_comb begin
    ctl = '0;
    unique case (state_q)
      S_PU_DEC: begin
        ctl.rd_sp    = 1'b1;
        ctl.ld_addr  = 1'b1;
        ctl.addr_sum = 1'b1;
        ctl.rf_we    = 1'b1;
        ctl.wr_sp    = 1'b1;
        ctl.step_dn  = 1'b1;
      end
      S_PU_SRC: ctl.ld_wdat = 1'b1;
      S_PU_MEM: begin
        ctl.mem_en = 1'b1;
        ctl.mem_we = 1'b1;
        ctl.done   = mem_ready;
      end
      S_PO_ADR: begin
        ctl.rd_sp   = 1'b1;
        ctl.ld_addr = 1'b1;
      end
      S_PO_MEM: begin
        ctl.mem_en   = 1'b1;
        ctl.cap_rdat = mem_ready;
      end
      S_PO_WB: begin
        ctl.rf_we = 1'b1;
        ctl.ld_cc = 1'b1;
      end
      S_PO_INC: begin
        ctl.rd_sp = 1'b1;
        ctl.rf_we = 1'b1;
        ctl.wr_sp = 1'b1;
        ctl.done  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.done |=> !ctl.done);

  // R8: the latched index cannot change mid-instruction
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl.done) |=> $stable(idx_q) && $stable(pop_q));

  // R6: a read access waits for ready
  p_wait_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PO_MEM && !mem_ready) |=> state_q == S_PO_MEM);

endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3,
  parameter int SP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_ctl_t      ctl,
  input  logic [RW-1:0] idx_q,
  input  logic [DW-1:0] rf_rd_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [RW-1:0] rf_rd_idx,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] load_val
);

  localparam logic [RW-1:0] SP_IDX = RW'(SP);
  localparam logic [DW-1:0] STEP   = DW'(2);

  logic [DW-1:0] addr_q, data_q, sum;

  assign sum        = ctl.step_dn ? (rf_rd_data - STEP) : (rf_rd_data + STEP);
  assign rf_rd_idx  = ctl.rd_sp ? SP_IDX : idx_q;
  assign rf_we      = ctl.rf_we;
  assign rf_wr_idx  = ctl.wr_sp ? SP_IDX : idx_q;
  assign rf_wr_data = ctl.wr_sp ? sum : data_q;
  assign mem_en     = ctl.mem_en;
  assign mem_we     = ctl.mem_we;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign load_val   = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (ctl.ld_addr) addr_q <= ctl.addr_sum ? sum : rf_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            data_q <= '0;
    else if (ctl.ld_wdat)  data_q <= rf_rd_data;
    else if (ctl.cap_rdat) data_q <= mem_rdata;
  end

endmodule

// File: rtl/stk_cc.sv
module stk_cc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] val,
  output logic [2:0]    cc
);

  logic [2:0] cc_d;

  always_comb begin
    if (val[DW-1])       cc_d = 3'b100;
    else if (val == '0)  cc_d = 3'b010;
    else                 cc_d = 3'b001;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cc <= 3'b010;
    else if (ld) cc <= cc_d;
  end

  // R4: exactly one flag set at all times
  p_cc_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1);

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3,
  parameter int SP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_pop,
  input  logic [RW-1:0] reg_sel,
  output logic          done,
  output logic [RW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [2:0]    cc_nzp
);

  logic          rst_m, rst_q;
  stk_ctl_t      ctl;
  logic [RW-1:0] idx_q;
  logic          pop_q, busy;
  logic [DW-1:0] load_val;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  stk_ctrl #(.RW(RW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (start),
    .is_pop    (op_pop),
    .reg_idx   (reg_sel),
    .mem_ready (mem_ready),
    .ctl       (ctl),
    .idx_q     (idx_q),
    .pop_q     (pop_q),
    .busy      (busy)
  );

  stk_dp #(.DW(DW), .RW(RW), .SP(SP)) u_dp (
    .clk        (clk),
    .rst_n      (rst_q),
    .ctl        (ctl),
    .idx_q      (idx_q),
    .rf_rd_data (rf_rd_data),
    .mem_rdata  (mem_rdata),
    .rf_rd_idx  (rf_rd_idx),
    .rf_we      (rf_we),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .load_val   (load_val)
  );

  stk_cc #(.DW(DW)) u_cc (
    .clk   (clk),
    .rst_n (rst_q),
    .ld    (ctl.ld_cc),
    .val   (load_val),
    .cc    (cc_nzp)
  );

  assign done = ctl.done;

  // R6: access held steady until ready
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_en && !mem_ready) |=> mem_en && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata));

  // R5: flags untouched while a push runs
  p_push_keeps_cc_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && !pop_q) |=> $stable(cc_nzp));

  // R1: a push never reads memory
  p_push_writes_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_en && !pop_q) |-> mem_we);

endmodule

// File: tb/test_stk_seq.sv
module test_stk_seq;

  logic        clk = 1'b0;
  logic        rst_n, start, op_pop, done, rf_we, mem_en, mem_we, mem_ready;
  logic [2:0]  reg_sel, rf_rd_idx, rf_wr_idx, cc_nzp;
  logic [15:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata;

  logic [15:0] rf   [8];
  logic [15:0] mem  [256];
  logic [15:0] rrf  [8];
  logic [15:0] rmem [256];
  logic [2:0]  rcc;
  int unsigned mcnt = 0;
  int total = 0, bad = 0;
  bit quiet_bad;

  always #5 clk = ~clk;

  stk_seq i_stk_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop), .reg_sel(reg_sel),
    .done(done), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .cc_nzp(cc_nzp)
  );

  // register file and fixed-latency memory models
  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem[mem_addr[8:1]];
  assign mem_ready  = mem_en && (mcnt == 4);

  always @(posedge clk) begin
    if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
    if (mem_en) begin
      if (mem_ready) begin
        mcnt <= 0;
        if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  function automatic logic [2:0] flags_of(input logic [15:0] v);
    if (v[15])          return 3'b100;
    else if (v == 16'h0) return 3'b010;
    else                 return 3'b001;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input int i, input logic [15:0] v);
    rf[i] = v; rrf[i] = v;
  endtask

  task automatic set_mem(input logic [15:0] a, input logic [15:0] v);
    mem[a[8:1]] = v; rmem[a[8:1]] = v;
  endtask

  // run one instruction; poke = try a second start mid-flight
  task automatic run(input bit pop, input logic [2:0] idx, input string tag, input bit poke);
    logic [15:0] a, v;
    int lat, n;
    if (!pop) begin
      a = rrf[6] - 16'd2;
      rrf[6] = a;
      rmem[a[8:1]] = rrf[idx];
      lat = 7;
    end else begin
      a = rrf[6];
      v = rmem[a[8:1]];
      rrf[idx] = v;
      rrf[6] = rrf[6] + 16'd2;
      rcc = flags_of(v);
      lat = 8;
    end
    start = 1'b1; op_pop = pop; reg_sel = idx;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      if (poke && n == 3) begin
        start = 1'b1; op_pop = ~pop; reg_sel = 3'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk({tag, " R7 latency"}, 16'(n), 16'(lat));
    @(negedge clk);
    chk({tag, " R7 done pulse"}, {15'b0, done}, 16'd0);
    for (int i = 0; i < 8; i++)
      chk($sformatf("%s reg%0d", tag, i), rf[i], rrf[i]);
    chk({tag, " mem word"}, mem[a[8:1]], rmem[a[8:1]]);
    chk({tag, pop ? " R4 flags" : " R5 flags"}, {13'b0, cc_nzp}, {13'b0, rcc});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d2c);
    start = 1'b0; op_pop = 1'b0; reg_sel = 3'd0;
    for (int i = 0; i < 8; i++) set_reg(i, 16'h0);
    for (int i = 0; i < 256; i++) set_mem(16'(i * 2), 16'(i * 16'h0101));
    rcc = 3'b010;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", {15'b0, done}, 16'd0);
    chk("R9 mem_en", {15'b0, mem_en}, 16'd0);
    chk("R9 rf_we", {15'b0, rf_we}, 16'd0);
    chk("R9 flags", {13'b0, cc_nzp}, 16'h0002);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: basic push and pop
    set_reg(6, 16'h0100); set_reg(1, 16'h1234);
    run(1'b0, 3'd1, "R1 push", 1'b0);
    run(1'b1, 3'd2, "R3 pop", 1'b0);
    // R4: zero, negative, positive loads
    set_mem(16'h0040, 16'h0000); set_reg(6, 16'h0040);
    run(1'b1, 3'd3, "R4 zero", 1'b0);
    set_mem(16'h0050, 16'h8001); set_reg(6, 16'h0050);
    run(1'b1, 3'd3, "R4 neg", 1'b0);
    set_mem(16'h0060, 16'h7fff); set_reg(6, 16'h0060);
    run(1'b1, 3'd4, "R4 pos", 1'b0);
    // R5: push after a negative load keeps flags
    set_mem(16'h0070, 16'hf000); set_reg(6, 16'h0070);
    run(1'b1, 3'd0, "R4 neg2", 1'b0);
    run(1'b0, 3'd5, "R5 push", 1'b0);
    // R2: push of the stack pointer itself
    set_reg(6, 16'h0080);
    run(1'b0, 3'd6, "R2 push sp", 1'b0);
    // R3: pop into the stack pointer
    set_mem(16'h0090, 16'h0020); set_reg(6, 16'h0090);
    run(1'b1, 3'd6, "R3 pop sp", 1'b0);
    // R10: wrap both ways
    set_reg(6, 16'h0000); set_reg(2, 16'hbeef);
    run(1'b0, 3'd2, "R10 push wrap", 1'b0);
    chk("R10 sp after push", rf[6], 16'hfffe);
    run(1'b1, 3'd7, "R10 pop wrap", 1'b0);
    chk("R10 sp after pop", rf[6], 16'h0000);
    // R8: start raised mid-instruction, then a quiet window
    set_reg(6, 16'h00a0); set_reg(3, 16'h5a5a);
    run(1'b0, 3'd3, "R8 push poked", 1'b1);
    quiet_bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || mem_en || rf_we) quiet_bad = 1'b1;
    end
    chk("R8 quiet after push", {15'b0, quiet_bad}, 16'd0);
    run(1'b1, 3'd4, "R8 pop poked", 1'b1);
    quiet_bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || mem_en || rf_we) quiet_bad = 1'b1;
    end
    chk("R8 quiet after pop", {15'b0, quiet_bad}, 16'd0);

    // random mix (R1 R3 R4 R5 R6 R7)
    for (int t = 0; t < 80; t++) begin
      logic [2:0] ri;
      if (t % 10 == 0) set_reg(6, 16'($urandom));
      if (t % 7 == 0) set_reg(int'($urandom_range(0, 7)), 16'($urandom));
      if (t % 5 == 0) set_mem(rrf[6], ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom));
      ri = 3'($urandom_range(0, 7));
      run(1'($urandom_range(0, 1)), ri, "R6 random", 1'b0);
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule